// File: doc/BRIEF.md
# Supply Supervisor with Fault Latch

This block decides, cycle by cycle, whether a switching sequencer is allowed to run. It watches digitized comparator flags for the supply rail, a flag for the feedback node sitting above its open-loop level, and a flag for the auxiliary-winding sample sitting above its overvoltage reference. It drives the enable of the startup current source, the run enable of the sequencer, a protection latch indicator and a two-bit cause code.

The rail sequencing uses three levels. The startup source charges the rail until the turn-on flag is seen. Switching then runs until the rail drops under the run level. After that the block waits, with the startup source off, until the rail also drops under the shutdown level, and only then does it recharge. An open-loop fault recovers through this same discharge-and-recharge cycle. A rail overvoltage or an auxiliary-winding overvoltage sets a latch that only the power-on reset clears. The auxiliary flag is blanked for a fixed interval after every turn-off pulse from the sequencer, so that leakage ringing is ignored. All debounce and blanking lengths are parameters counted in clock cycles.

Top module: `pwr_guard`

## Requirements
- R1: During and right after reset, startup_en_o is 1, run_en_o is 0, latched_o is 0 and cause_o is 0.
- R2: While charging, the clock edge that samples vdd_on_i high turns startup_en_o off and run_en_o on together, and cause_o becomes 0.
- R3: While running, the edge that samples vdd_run_i low turns run_en_o off. startup_en_o stays off until an edge samples vdd_live_i low, and that edge turns it on. run_en_o and startup_en_o are never high together.
- R4: While running, fb_high_i high at OLP_CYC consecutive edges turns run_en_o off at the last of them, with cause_o = 1. Recovery then follows the discharge cycle of R3.
- R5: A fault flag that goes low before its debounce length completes restarts that fault's count from zero. Nothing trips on such a partial run.
- R6: While running, vdd_ovp_i high at VOV_CYC consecutive edges sets latched_o and clears run_en_o, with cause_o = 2.
- R7: aux_high_i is counted only when the block is running and the sampling window is open. The window opens only after a turn-off pulse (gate_off_i) has been seen in the current run and BLANK_CYC cycles have passed since the most recent such pulse. A new pulse closes the window again and restarts the auxiliary count.
- R8: aux_high_i high at AOV_CYC consecutive edges with the window open sets latched_o and clears run_en_o, with cause_o = 3.
- R9: Once latched, no input other than rst changes any output. startup_en_o and run_en_o stay 0.
- R10: When several faults complete in the same cycle, cause_o takes the highest priority: auxiliary overvoltage (3), then rail overvoltage (2), then open loop (1), then undervoltage (0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| vdd_on_i | input | 1 | Rail above turn-on level |
| vdd_run_i | input | 1 | Rail above run-off level |
| vdd_live_i | input | 1 | Rail above shutdown level |
| vdd_ovp_i | input | 1 | Rail above overvoltage level |
| fb_high_i | input | 1 | Feedback above open-loop level |
| aux_high_i | input | 1 | Auxiliary sample above overvoltage reference |
| gate_off_i | input | 1 | One-cycle pulse at each switch turn-off |
| startup_en_o | output | 1 | Startup current source enable |
| run_en_o | output | 1 | Sequencer run enable |
| latched_o | output | 1 | Protection latch set |
| cause_o | output | 2 | Cause of last stop: 0 undervoltage, 1 open loop, 2 rail overvoltage, 3 auxiliary overvoltage |

## Verification
Feedback bursts one cycle shorter than the open-loop length, followed by a burst of exactly that length, separate a correct restart of the count from a count that accumulates or trips one cycle off. Auxiliary overvoltage is held high before any turn-off, under turn-off pulses repeated faster than the blanking, and after a single pulse. This shows whether the window and its blanking really gate the count. Fault flags that overlap so that two counts complete on the same edge expose the priority order, and toggling every flag while latched shows whether the latch is truly final. A behavioural reference model runs alongside all of this and is compared with the outputs on every clock.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_RUN    = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_LATCH  = 2'd3
  } pg_state_e;

  typedef enum logic [1:0] {
    CAUSE_UV   = 2'd0,
    CAUSE_OLP  = 2'd1,
    CAUSE_VOV  = 2'd2,
    CAUSE_AOV  = 2'd3
  } pg_cause_e;

  localparam int unsigned N_FAULT = 3;
  localparam int unsigned F_OLP = 0;
  localparam int unsigned F_VOV = 1;
  localparam int unsigned F_AOV = 2;
endpackage

// File: rtl/pg_debounce.sv
module pg_debounce #(
  parameter int unsigned N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned W = (N < 2) ? 1 : $clog2(N + 1);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;
  logic         live;

  assign live   = en_i && cond_i;
  assign done_o = live && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !live || done_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  a_r5_drop_restarts: assert property (@(posedge clk) disable iff (rst)
    !live |=> (cnt_q == '0));
endmodule

// File: rtl/pg_blanker.sv
module pg_blanker #(
  parameter int unsigned BLANK_CYC = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic gate_off_i,
  output logic open_o
);
  localparam int unsigned W = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [W-1:0] LOAD = W'(BLANK_CYC);

  logic [W-1:0] blk_q;
  logic         armed_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      blk_q   <= '0;
      armed_q <= 1'b0;
    end else if (gate_off_i) begin
      blk_q   <= LOAD;
      armed_q <= 1'b1;
    end else if (blk_q != '0) begin
      blk_q   <= blk_q - 1'b1;
    end
  end

  assign open_o = armed_q && (blk_q == '0);

  a_r7_closed_after_off: assert property (@(posedge clk) disable iff (rst)
    (en_i && gate_off_i && BLANK_CYC > 0) |=> !open_o);
  a_r7_closed_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !open_o);
endmodule

// File: rtl/pg_seq.sv
module pg_seq
  import pg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                vdd_on_i,
  input  logic                vdd_run_i,
  input  logic                vdd_live_i,
  input  logic [N_FAULT-1:0]  trip_i,
  output logic                startup_en_o,
  output logic                run_en_o,
  output logic                latched_o,
  output logic [1:0]          cause_o
);
  pg_state_e state_q, state_d;
  pg_cause_e cause_q, cause_d;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      ST_CHARGE: if (vdd_on_i) begin
        state_d = ST_RUN;
        cause_d = CAUSE_UV;
      end
      ST_RUN: begin
        if (trip_i[F_AOV]) begin
          state_d = ST_LATCH; cause_d = CAUSE_AOV;
        end else if (trip_i[F_VOV]) begin
          state_d = ST_LATCH; cause_d = CAUSE_VOV;
        end else if (trip_i[F_OLP]) begin
          state_d = ST_DRAIN; cause_d = CAUSE_OLP;
        end else if (!vdd_run_i) begin
          state_d = ST_DRAIN; cause_d = CAUSE_UV;
        end
      end
      ST_DRAIN: if (!vdd_live_i) state_d = ST_CHARGE;
      ST_LATCH: state_d = ST_LATCH;
      default:  state_d = ST_CHARGE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_CHARGE;
      cause_q      <= CAUSE_UV;
      startup_en_o <= 1'b1;
      run_en_o     <= 1'b0;
      latched_o    <= 1'b0;
    end else begin
      state_q      <= state_d;
      cause_q      <= cause_d;
      startup_en_o <= (state_d == ST_CHARGE);
      run_en_o     <= (state_d == ST_RUN);
      latched_o    <= (state_d == ST_LATCH);
    end
  end

  assign cause_o = cause_q;

  a_r2_run_needs_on: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en_o) |-> $past(vdd_on_i));
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(run_en_o && startup_en_o));
  a_r3_recharge_below_live: assert property (@(posedge clk) disable iff (rst)
    $rose(startup_en_o) |-> !$past(vdd_live_i));
  a_r9_latch_final: assert property (@(posedge clk) disable iff (rst)
    latched_o |=> (latched_o && !run_en_o && !startup_en_o && $stable(cause_o)));
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pg_pkg::*;
#(
  parameter int unsigned OLP_CYC   = 6_500_000,
  parameter int unsigned VOV_CYC   = 18_750,
  parameter int unsigned AOV_CYC   = 18_750,
  parameter int unsigned BLANK_CYC = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vdd_on_i,
  input  logic       vdd_run_i,
  input  logic       vdd_live_i,
  input  logic       vdd_ovp_i,
  input  logic       fb_high_i,
  input  logic       aux_high_i,
  input  logic       gate_off_i,
  output logic       startup_en_o,
  output logic       run_en_o,
  output logic       latched_o,
  output logic [1:0] cause_o
);
  localparam int unsigned DB_LEN [N_FAULT] = '{OLP_CYC, VOV_CYC, AOV_CYC};

  logic               win_open;
  logic [N_FAULT-1:0] cond;
  logic [N_FAULT-1:0] trip;

  pg_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk        (clk),
    .rst        (rst),
    .en_i       (run_en_o),
    .gate_off_i (gate_off_i),
    .open_o     (win_open)
  );

  assign cond[F_OLP] = fb_high_i;
  assign cond[F_VOV] = vdd_ovp_i;
  assign cond[F_AOV] = aux_high_i && win_open;

  for (genvar g = 0; g < N_FAULT; g++) begin : g_db
    pg_debounce #(.N(DB_LEN[g])) u_db (
      .clk    (clk),
      .rst    (rst),
      .en_i   (run_en_o),
      .cond_i (cond[g]),
      .done_o (trip[g])
    );
  end

  pg_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .vdd_on_i     (vdd_on_i),
    .vdd_run_i    (vdd_run_i),
    .vdd_live_i   (vdd_live_i),
    .trip_i       (trip),
    .startup_en_o (startup_en_o),
    .run_en_o     (run_en_o),
    .latched_o    (latched_o),
    .cause_o      (cause_o)
  );

  a_r8_latch_needs_window: assert property (@(posedge clk) disable iff (rst)
    ($rose(latched_o) && cause_o == 2'd3) |-> $past(win_open && aux_high_i));
  a_r6_latch_needs_ovp: assert property (@(posedge clk) disable iff (rst)
    ($rose(latched_o) && cause_o == 2'd2) |-> $past(vdd_ovp_i));
endmodule

// File: tb/sim_pwr_guard.sv
`timescale 1ns/1ps
module sim_pwr_guard;
  localparam int OLP = 40, VOV = 12, AOV = 8, BLK = 5;

  logic clk = 0, rst = 1;
  logic vdd_on = 0, vdd_run = 0, vdd_live = 0, vdd_ovp = 0;
  logic fb = 0, aux = 0, goff = 0;
  logic su, ru, la;
  logic [1:0] cause;

  always #4 clk = ~clk;

  pwr_guard #(.OLP_CYC(OLP), .VOV_CYC(VOV), .AOV_CYC(AOV), .BLANK_CYC(BLK)) u0 (
    .clk(clk), .rst(rst), .vdd_on_i(vdd_on), .vdd_run_i(vdd_run),
    .vdd_live_i(vdd_live), .vdd_ovp_i(vdd_ovp), .fb_high_i(fb),
    .aux_high_i(aux), .gate_off_i(goff), .startup_en_o(su), .run_en_o(ru),
    .latched_o(la), .cause_o(cause));

  int tests = 0, fails = 0;
  string cur = "R1";
  bit cmp_on = 0;

  // behavioural reference: 0 charge, 1 run, 2 drain, 3 latch
  int m_st = 0, m_code = 0, c_olp = 0, c_vov = 0, c_aov = 0, m_blk = 0;
  bit m_arm = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_code = 0; c_olp = 0; c_vov = 0; c_aov = 0; m_blk = 0; m_arm = 0;
    end else begin
      bit running, win, t_o, t_v, t_a;
      running = (m_st == 1);
      win = m_arm && (m_blk == 0);
      t_o = running && fb && (c_olp == OLP - 1);
      t_v = running && vdd_ovp && (c_vov == VOV - 1);
      t_a = running && win && aux && (c_aov == AOV - 1);
      c_olp = (running && fb && !t_o) ? c_olp + 1 : 0;
      c_vov = (running && vdd_ovp && !t_v) ? c_vov + 1 : 0;
      c_aov = (running && win && aux && !t_a) ? c_aov + 1 : 0;
      if (!running) begin m_blk = 0; m_arm = 0; end
      else if (goff) begin m_blk = BLK; m_arm = 1; end
      else if (m_blk > 0) m_blk--;
      case (m_st)
        0: if (vdd_on) begin m_st = 1; m_code = 0; end
        1: if (t_a) begin m_st = 3; m_code = 3; end
           else if (t_v) begin m_st = 3; m_code = 2; end
           else if (t_o) begin m_st = 2; m_code = 1; end
           else if (!vdd_run) begin m_st = 2; m_code = 0; end
        2: if (!vdd_live) m_st = 0;
        default: ;
      endcase
    end
  end

  always @(negedge clk) if (cmp_on) begin
    tests++;
    if (su !== (m_st == 0) || ru !== (m_st == 1) || la !== (m_st == 3) || cause !== 2'(m_code)) begin
      fails++;
      $display("FAIL %s model: got su=%b ru=%b la=%b cause=%0d exp su=%b ru=%b la=%b cause=%0d",
               cur, su, ru, la, cause, m_st == 0, m_st == 1, m_st == 3, m_code);
    end
  end

  task automatic expect_out(string req, logic esu, logic eru, logic ela, logic [1:0] ec);
    tests++;
    if (su !== esu || ru !== eru || la !== ela || cause !== ec) begin
      fails++;
      $display("FAIL %s: got su=%b ru=%b la=%b cause=%0d exp su=%b ru=%b la=%b cause=%0d",
               req, su, ru, la, cause, esu, eru, ela, ec);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_off();
    goff = 1; cyc(1); goff = 0;
  endtask

  task automatic power_up();
    vdd_live = 1; vdd_run = 1; cyc(3);
    vdd_on = 1; cyc(1); vdd_on = 0;
  endtask

  task automatic do_reset();
    rst = 1; {vdd_on, vdd_run, vdd_live, vdd_ovp, fb, aux, goff} = '0; cyc(3);
    rst = 0; cyc(1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got running exp finished");
    summary();
    $finish;
  end

  initial begin
    cyc(2);
    cur = "R1"; expect_out("R1", 1, 0, 0, 0);   // during reset
    rst = 0; cyc(1); cmp_on = 1;
    expect_out("R1", 1, 0, 0, 0);
    // R2: charge then turn on
    cur = "R2"; vdd_live = 1; vdd_run = 1; cyc(4);
    expect_out("R2", 1, 0, 0, 0);
    vdd_on = 1; cyc(1); vdd_on = 0;
    expect_out("R2", 0, 1, 0, 0);
    // R5: partial open-loop bursts
    cur = "R5"; fb = 1; cyc(OLP - 1); fb = 0; cyc(1);
    expect_out("R5", 0, 1, 0, 0);
    fb = 1; cyc(OLP - 1);
    expect_out("R5", 0, 1, 0, 0);
    // R4: one more cycle completes it
    cur = "R4"; cyc(1); fb = 0;
    expect_out("R4", 0, 0, 0, 1);
    cyc(5); expect_out("R4", 0, 0, 0, 1);   // waits for discharge
    cur = "R3"; vdd_run = 0; cyc(3); expect_out("R3", 0, 0, 0, 1);
    vdd_live = 0; cyc(1); expect_out("R3", 1, 0, 0, 1);
    power_up(); expect_out("R4", 0, 1, 0, 0);
    // R3: undervoltage stop
    cur = "R3"; vdd_run = 0; cyc(1); expect_out("R3", 0, 0, 0, 0);
    vdd_live = 0; cyc(2); expect_out("R3", 1, 0, 0, 0);
    power_up();
    // R7: aux ignored before any turn-off and under fast pulses
    cur = "R7"; aux = 1; cyc(3 * AOV);
    expect_out("R7", 0, 1, 0, 0);
    for (int i = 0; i < 8; i++) begin pulse_off(); cyc(BLK - 1); end
    expect_out("R7", 0, 1, 0, 0);
    // R8: single pulse then window opens
    cur = "R8"; pulse_off(); cyc(BLK + AOV + 2);
    expect_out("R8", 0, 0, 1, 3);
    aux = 0;
    // R9: flags ignored while latched
    cur = "R9";
    vdd_on = 1; cyc(3); vdd_run = 0; vdd_live = 0; fb = 1; vdd_ovp = 1; cyc(VOV + 3);
    pulse_off(); vdd_on = 0; cyc(3);
    expect_out("R9", 0, 0, 1, 3);
    do_reset(); expect_out("R9", 1, 0, 0, 0);
    // R6: rail overvoltage
    cur = "R6"; power_up();
    vdd_ovp = 1; cyc(VOV - 1); expect_out("R6", 0, 1, 0, 0);
    cyc(1); vdd_ovp = 0; expect_out("R6", 0, 0, 1, 2);
    do_reset();
    // R10: open loop and rail overvoltage complete together
    cur = "R10"; power_up();
    fb = 1; cyc(OLP - VOV); vdd_ovp = 1; cyc(VOV);
    fb = 0; vdd_ovp = 0;
    expect_out("R10", 0, 0, 1, 2);
    do_reset();
    // R10: auxiliary and rail overvoltage complete together
    power_up(); pulse_off(); cyc(BLK + 1);
    vdd_ovp = 1; cyc(VOV - AOV); aux = 1; cyc(AOV);
    aux = 0; vdd_ovp = 0;
    expect_out("R10", 0, 0, 1, 3);
    do_reset();
    cyc(2);
    summary();
    $finish;
  end
endmodule